// File: doc/BRIEF.md
# 8-bit ALU with Condition Codes

This block is the arithmetic and logic stage of a small accumulator processor. Each request carries an operation number, two 8-bit operands and the current six-flag condition-code word. One clock later the block returns a 16-bit result and the updated flag word. Every operation updates the flags under its own rule. The block covers two's-complement add and subtract (with and without carry), compare, the bitwise operations, complement, negate, increment, decrement, clear, test, shifts and rotates, decimal adjust after a packed-BCD add, and an unsigned 8x8 multiply.

Alongside the operation, the block evaluates one of sixteen branch predicates against the incoming flag word. The sequencer can then resolve a conditional branch in the same pass. Instruction decoding, operand fetch and the write-back of results are handled by the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: A request is taken on a rising clock edge when `valid_i`=1. Its result, flags and branch decision appear on the outputs after that edge, and `valid_o` is high for exactly that one cycle. The asynchronous reset clears `result_o`, `ccr_o`, `take_o` and `valid_o` to zero.
- R2: While `valid_i`=0, `result_o`, `ccr_o` and `take_o` hold their last values, and `valid_o` is 0, whatever the other inputs carry.
- R3: The flag word is laid out as bit0 C, bit1 V, bit2 Z, bit3 N, bit4 I, bit5 H. I always passes through unchanged. H changes only for add (op 0) and add-with-carry (op 1), where it becomes the carry out of bit 3.
- R4: Add (0), add-with-carry (1), subtract (2), subtract-with-borrow (3) and compare (4) work on A and B, using C as the carry-in for ops 1 and 3. C is the carry out, or the borrow for ops 2 to 4. For adds, V is set when A and B have the same sign and the result's sign differs from it. For subtracts, V is set when A and B differ in sign and the result's sign differs from A's. Compare outputs A-B.
- R5: AND (5), OR (6), XOR (7) and bit-test (8, result A&B) clear V and leave C unchanged.
- R6: Complement (9) gives ~A with V=0 and C=1. Negate (10) gives 0-A, with V=1 only for A=0x80 and C=1 unless A=0.
- R7: Increment (11) and decrement (12) leave C unchanged. V is set for an increment of 0x7F and a decrement of 0x80.
- R8: Clear (13) gives 0 with N=0, Z=1, V=0, C=0. Test (14) outputs A with V=0 and C=0.
- R9: Shift-left (15), arithmetic shift-right (16), logical shift-right (17, which forces N=0), rotate-left (18) and rotate-right (19) put the bit shifted out into C. Rotates move the old C into the vacated bit. V = N xor C after the shift.
- R10: Decimal adjust (20) adds 0x06 when H=1 or the low nibble exceeds 9. It adds 0x60 when C=1, or the high nibble exceeds 9, or the high nibble exceeds 8 while the low nibble exceeds 9. C becomes old C OR the high correction, and V is cleared.
- R11: Multiply (21) outputs the 16-bit unsigned A*B, sets C to result bit 7, and leaves every other flag unchanged.
- R12: For ops 0 to 20, N and Z follow the low result byte and the high result byte is 0.
- R13: `cond_i` selects the branch predicate on `ccr_i`, registered into `take_o`. The encoding is: 0 always, 1 never, 2 higher (C|Z)=0, 3 lower-or-same (C|Z)=1, 4 C=0, 5 C=1, 6 Z=0, 7 Z=1, 8 V=0, 9 V=1, 10 N=0, 11 N=1, 12 greater-or-equal (N^V)=0, 13 less-than (N^V)=1, 14 greater Z|(N^V)=0, 15 less-or-equal Z|(N^V)=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 5 | Operation number |
| a_i | input | 8 | First operand (the only operand for unary ops) |
| b_i | input | 8 | Second operand |
| ccr_i | input | 6 | Incoming flag word |
| cond_i | input | 4 | Branch predicate select |
| valid_o | output | 1 | Result valid, one cycle |
| result_o | output | 16 | Result (high byte used only by multiply) |
| ccr_o | output | 6 | Updated flag word |
| take_o | output | 1 | Branch predicate outcome |

## Verification
The assertions check every cycle that I always passes through, that H is preserved outside the two add operations, and that multiply touches only C. They also check that Z and the zero high byte agree with the registered result, that clear produces its fixed flag pattern, and that the outputs hold while no request is present. The exact arithmetic is shown only by the bench's directed scenarios. This covers the V and C boundaries at 0x7F/0x80/0x00, the decimal-adjust corrections across nibble limits, the carry fed into rotates, and the truth table of all sixteen branch predicates.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW    = 8;
  localparam int PW    = 2 * DW;
  localparam int CCR_W = 6;
  localparam int OP_W  = 5;
  localparam int CND_W = 4;

  localparam int FC = 0;
  localparam int FV = 1;
  localparam int FZ = 2;
  localparam int FN = 3;
  localparam int FI = 4;
  localparam int FH = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_EOR = 5'd7,
    OP_BIT = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
    OP_DEC = 5'd12, OP_CLR = 5'd13, OP_TST = 5'd14, OP_ASL = 5'd15,
    OP_ASR = 5'd16, OP_LSR = 5'd17, OP_ROL = 5'd18, OP_ROR = 5'd19,
    OP_DAA = 5'd20, OP_MUL = 5'd21
  } alu_op_e;

  typedef enum logic [CND_W-1:0] {
    BR_ALW = 4'd0,  BR_NVR = 4'd1,  BR_HI = 4'd2,  BR_LS = 4'd3,
    BR_CC  = 4'd4,  BR_CS  = 4'd5,  BR_NE = 4'd6,  BR_EQ = 4'd7,
    BR_VC  = 4'd8,  BR_VS  = 4'd9,  BR_PL = 4'd10, BR_MI = 4'd11,
    BR_GE  = 4'd12, BR_LT  = 4'd13, BR_GT = 4'd14, BR_LE = 4'd15
  } br_cond_e;
endpackage

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
(
  input  alu_op_e          op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic [CCR_W-1:0] ccr_i,
  output logic [PW-1:0]    res_o,
  output logic [CCR_W-1:0] ccr_o
);
  localparam logic [DW-1:0] ONE  = DW'(1);
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

  logic [PW-1:0] prod;
  assign prod = PW'(a_i) * PW'(b_i);

  logic [DW:0]   ext;
  logic [DW-1:0] m, s, r, corr;
  logic          cin, nz_upd, shf, lo_adj, hi_adj;
  logic [CCR_W-1:0] f;

  always_comb begin
    f      = ccr_i;
    r      = '0;
    ext    = '0;
    m      = a_i;
    s      = b_i;
    cin    = 1'b0;
    nz_upd = 1'b1;
    shf    = 1'b0;
    lo_adj = (ccr_i[FH] || a_i[3:0] > 4'd9);
    hi_adj = (ccr_i[FC] || a_i[7:4] > 4'd9 || (a_i[7:4] > 4'd8 && a_i[3:0] > 4'd9));
    corr   = {hi_adj ? 4'h6 : 4'h0, lo_adj ? 4'h6 : 4'h0};
    unique case (op_i)
      OP_ADD, OP_ADC: begin
        cin   = (op_i == OP_ADC) && ccr_i[FC];
        ext   = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin};
        r     = ext[DW-1:0];
        f[FC] = ext[DW];
        f[FV] = (a_i[DW-1] == b_i[DW-1]) && (r[DW-1] != a_i[DW-1]);
        f[FH] = a_i[4] ^ b_i[4] ^ r[4];
      end
      OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
        if (op_i == OP_NEG) begin
          m = '0;
          s = a_i;
        end
        cin   = (op_i == OP_SBC) && ccr_i[FC];
        ext   = {1'b0, m} - {1'b0, s} - {{DW{1'b0}}, cin};
        r     = ext[DW-1:0];
        f[FC] = ext[DW];
        f[FV] = (m[DW-1] != s[DW-1]) && (r[DW-1] != m[DW-1]);
      end
      OP_AND, OP_BIT: begin r = a_i & b_i; f[FV] = 1'b0; end
      OP_OR:          begin r = a_i | b_i; f[FV] = 1'b0; end
      OP_EOR:         begin r = a_i ^ b_i; f[FV] = 1'b0; end
      OP_COM:         begin r = ~a_i; f[FV] = 1'b0; f[FC] = 1'b1; end
      OP_INC:         begin r = a_i + ONE; f[FV] = (a_i == SMAX); end
      OP_DEC:         begin r = a_i - ONE; f[FV] = (a_i == SMIN); end
      OP_CLR:         begin r = '0; f[FV] = 1'b0; f[FC] = 1'b0; end
      OP_TST:         begin r = a_i; f[FV] = 1'b0; f[FC] = 1'b0; end
      OP_ASL: begin r = {a_i[DW-2:0], 1'b0};        f[FC] = a_i[DW-1]; shf = 1'b1; end
      OP_ASR: begin r = {a_i[DW-1], a_i[DW-1:1]};   f[FC] = a_i[0];    shf = 1'b1; end
      OP_LSR: begin r = {1'b0, a_i[DW-1:1]};        f[FC] = a_i[0];    shf = 1'b1; end
      OP_ROL: begin r = {a_i[DW-2:0], ccr_i[FC]};   f[FC] = a_i[DW-1]; shf = 1'b1; end
      OP_ROR: begin r = {ccr_i[FC], a_i[DW-1:1]};   f[FC] = a_i[0];    shf = 1'b1; end
      OP_DAA: begin
        ext   = {1'b0, a_i} + {1'b0, corr};
        r     = ext[DW-1:0];
        f[FC] = ccr_i[FC] | hi_adj;
        f[FV] = 1'b0;
      end
      OP_MUL: begin
        nz_upd = 1'b0;
        f[FC]  = prod[DW-1];
      end
      default: nz_upd = 1'b0;
    endcase
    if (nz_upd) begin
      f[FN] = r[DW-1];
      f[FZ] = (r == '0);
    end
    if (shf) f[FV] = f[FN] ^ f[FC];
    ccr_o = f;
    res_o = (op_i == OP_MUL) ? prod : {{DW{1'b0}}, r};
  end
endmodule

// File: rtl/acc_alu_branch.sv
module acc_alu_branch
  import acc_alu_pkg::*;
(
  input  br_cond_e         cond_i,
  input  logic [CCR_W-1:0] ccr_i,
  output logic             take_o
);
  logic c, v, z, n, nv;
  assign c  = ccr_i[FC];
  assign v  = ccr_i[FV];
  assign z  = ccr_i[FZ];
  assign n  = ccr_i[FN];
  assign nv = n ^ v;

  always_comb begin
    unique case (cond_i)
      BR_ALW: take_o = 1'b1;
      BR_NVR: take_o = 1'b0;
      BR_HI:  take_o = ~(c | z);
      BR_LS:  take_o = c | z;
      BR_CC:  take_o = ~c;
      BR_CS:  take_o = c;
      BR_NE:  take_o = ~z;
      BR_EQ:  take_o = z;
      BR_VC:  take_o = ~v;
      BR_VS:  take_o = v;
      BR_PL:  take_o = ~n;
      BR_MI:  take_o = n;
      BR_GE:  take_o = ~nv;
      BR_LT:  take_o = nv;
      BR_GT:  take_o = ~(z | nv);
      BR_LE:  take_o = z | nv;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic [CCR_W-1:0] ccr_i,
  input  logic [CND_W-1:0] cond_i,
  output logic             valid_o,
  output logic [PW-1:0]    result_o,
  output logic [CCR_W-1:0] ccr_o,
  output logic             take_o
);
  logic [PW-1:0]    res_d;
  logic [CCR_W-1:0] ccr_d;
  logic             take_d;

  acc_alu_core u_core (
    .op_i  (alu_op_e'(op_i)),
    .a_i   (a_i),
    .b_i   (b_i),
    .ccr_i (ccr_i),
    .res_o (res_d),
    .ccr_o (ccr_d)
  );

  acc_alu_branch u_branch (
    .cond_i (br_cond_e'(cond_i)),
    .ccr_i  (ccr_i),
    .take_o (take_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      ccr_o    <= '0;
      take_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        ccr_o    <= ccr_d;
        take_o   <= take_d;
      end
    end
  end

  a_r1_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(result_o) && $stable(ccr_o) && $stable(take_o));

  a_r3_i_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ccr_o[FI] == $past(ccr_i[FI]));

  a_r3_h_only_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i != OP_ADD && op_i != OP_ADC |=> ccr_o[FH] == $past(ccr_i[FH]));

  a_r8_clr_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CLR |=> result_o == '0 && ccr_o[3:0] == 4'b0100);

  a_r11_mul_only_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_MUL |=>
      ccr_o[CCR_W-1:1] == $past(ccr_i[CCR_W-1:1]) && ccr_o[FC] == result_o[DW-1]);

  a_r12_z_low_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i < OP_MUL |=>
      ccr_o[FZ] == (result_o[DW-1:0] == '0) && result_o[PW-1:DW] == '0);

  a_r13_always_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cond_i < 4'd2 |=> take_o == ($past(cond_i) == 4'd0));
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [5:0] ccr_i = '0;
  logic [3:0] cond_i = '0;
  logic       valid_o, take_o;
  logic [15:0] result_o;
  logic [5:0] ccr_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  acc_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .ccr_i(ccr_i), .cond_i(cond_i),
    .valid_o(valid_o), .result_o(result_o), .ccr_o(ccr_o), .take_o(take_o)
  );

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic logic pred(logic [5:0] cc, int cond);
    logic c, v, z, n;
    c = cc[0]; v = cc[1]; z = cc[2]; n = cc[3];
    case (cond)
      0: return 1'b1;       1: return 1'b0;
      2: return !(c || z);  3: return c || z;
      4: return !c;         5: return c;
      6: return !z;         7: return z;
      8: return !v;         9: return v;
      10: return !n;        11: return n;
      12: return n == v;    13: return n != v;
      14: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  // expected {take, ccr, result} from the requirement text
  function automatic logic [22:0] model(int op, int a, int b, logic [5:0] cc, int cond);
    int r = 0, sr = 0, ci;
    logic [5:0] f = cc;
    logic nz = 1'b1, sh = 1'b0;
    ci = cc[0];
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        r = a + b + ci; sr = sx(a) + sx(b) + ci;
        f[0] = r > 255; f[1] = (sr > 127) || (sr < -128);
        f[5] = ((a % 16) + (b % 16) + ci) > 15; r = r % 256;
      end
      2, 3, 4: begin
        if (op != 3) ci = 0;
        r = a - b - ci; sr = sx(a) - sx(b) - ci;
        f[0] = r < 0; f[1] = (sr > 127) || (sr < -128); r = (r + 512) % 256;
      end
      5, 8: begin r = a & b; f[1] = 0; end
      6:  begin r = a | b; f[1] = 0; end
      7:  begin r = a ^ b; f[1] = 0; end
      9:  begin r = 255 - a; f[1] = 0; f[0] = 1; end
      10: begin r = (256 - a) % 256; f[1] = (a == 128); f[0] = (a != 0); end
      11: begin r = (a + 1) % 256; f[1] = (a == 127); end
      12: begin r = (a + 255) % 256; f[1] = (a == 128); end
      13: begin r = 0; f[1] = 0; f[0] = 0; end
      14: begin r = a; f[1] = 0; f[0] = 0; end
      15: begin r = (a * 2) % 256; f[0] = a >= 128; sh = 1; end
      16: begin r = (a / 2) + (a >= 128 ? 128 : 0); f[0] = a % 2; sh = 1; end
      17: begin r = a / 2; f[0] = a % 2; sh = 1; end
      18: begin r = (a * 2 + ci) % 256; f[0] = a >= 128; sh = 1; end
      19: begin r = a / 2 + ci * 128; f[0] = a % 2; sh = 1; end
      20: begin
        int adj = 0;
        if (cc[5] || (a % 16) > 9) adj += 6;
        if (cc[0] || a > 'h99) begin adj += 'h60; f[0] = 1; end
        r = (a + adj) % 256; f[1] = 0;
      end
      default: begin r = a * b; f[0] = (r / 128) % 2; nz = 0; end
    endcase
    if (nz) begin f[3] = r >= 128; f[2] = (r == 0); end
    if (sh) f[1] = f[3] ^ f[0];
    return {pred(cc, cond), f, 16'(r)};
  endfunction

  task automatic chk(string tag, logic [23:0] got, logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(string tag, int op, int a, int b, logic [5:0] cc, int cond);
    logic [22:0] e;
    e = model(op, a, b, cc, cond);
    @(negedge clk);
    op_i = 5'(op); a_i = 8'(a); b_i = 8'(b); ccr_i = cc; cond_i = 4'(cond);
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk(tag, {valid_o, take_o, ccr_o, result_o}, {1'b1, e});
  endtask

  task automatic t_reset;  // R1
    chk("R1 reset", {valid_o, take_o, ccr_o, result_o}, 24'h0);
  endtask

  task automatic t_arith;  // R4, R3
    run("R4 add ovf",  0, 'h7F, 'h01, 6'h00, 0);
    run("R4 add carry", 0, 'hFF, 'h01, 6'h00, 0);
    run("R3 adc I kept", 1, 'h10, 'h20, 6'h11, 0);
    run("R4 sub ovf",  2, 'h80, 'h01, 6'h00, 0);
    run("R4 sub borrow", 2, 'h00, 'h01, 6'h00, 0);
    run("R4 sbc zero", 3, 'h06, 'h05, 6'h01, 0);
    run("R4 cmp equal", 4, 'h42, 'h42, 6'h00, 0);
    run("R3 sub keeps H", 2, 'h08, 'h08, 6'h30, 0);
  endtask

  task automatic t_logic;  // R5
    run("R5 and", 5, 'hF0, 'h3C, 6'h03, 0);
    run("R5 or",  6, 'h80, 'h01, 6'h02, 0);
    run("R5 eor", 7, 'hFF, 'hFF, 6'h01, 0);
    run("R5 bit", 8, 'h80, 'h81, 6'h02, 0);
  endtask

  task automatic t_unary;  // R6 R7 R8
    run("R6 com",     9,  'h00, 0, 6'h02, 0);
    run("R6 neg 80",  10, 'h80, 0, 6'h00, 0);
    run("R6 neg 00",  10, 'h00, 0, 6'h01, 0);
    run("R6 neg 01",  10, 'h01, 0, 6'h00, 0);
    run("R7 inc 7F",  11, 'h7F, 0, 6'h01, 0);
    run("R7 dec 80",  12, 'h80, 0, 6'h00, 0);
    run("R7 dec 00",  12, 'h00, 0, 6'h01, 0);
    run("R8 clr",     13, 'h55, 0, 6'h3F, 0);
    run("R8 tst",     14, 'h80, 0, 6'h03, 0);
  endtask

  task automatic t_shift;  // R9
    run("R9 asl",      15, 'h81, 0, 6'h00, 0);
    run("R9 asr",      16, 'h81, 0, 6'h00, 0);
    run("R9 lsr",      17, 'h01, 0, 6'h08, 0);
    run("R9 rol c1",   18, 'h80, 0, 6'h01, 0);
    run("R9 ror c0",   19, 'h01, 0, 6'h00, 0);
    run("R9 ror c1",   19, 'h00, 0, 6'h01, 0);
  endtask

  task automatic t_daa;  // R10
    run("R10 daa H",    20, 'h41, 0, 6'h20, 0);
    run("R10 daa 9A",   20, 'h9A, 0, 6'h02, 0);
    run("R10 daa lo",   20, 'h3C, 0, 6'h00, 0);
    run("R10 daa A0",   20, 'hA0, 0, 6'h00, 0);
    run("R10 daa C in", 20, 'h15, 0, 6'h01, 0);
  endtask

  task automatic t_mul;  // R11
    run("R11 mul FFxFF", 21, 'hFF, 'hFF, 6'h00, 0);
    run("R11 mul 10x08", 21, 'h10, 'h08, 6'h2E, 0);
  endtask

  task automatic t_hold;  // R2
    logic [22:0] snap;
    run("R2 setup", 0, 'h12, 'h34, 6'h00, 2);
    snap = {take_o, ccr_o, result_o};
    @(negedge clk);
    op_i = 5'd13; a_i = 8'hAA; b_i = 8'h55; ccr_i = 6'h3F; cond_i = 4'd1;
    repeat (3) @(negedge clk);
    chk("R2 hold", {valid_o, take_o, ccr_o, result_o}, {1'b0, snap});
  endtask

  task automatic t_branch;  // R13
    logic [5:0] pats [8] = '{6'h00, 6'h01, 6'h02, 6'h04, 6'h08, 6'h0A, 6'h05, 6'h0C};
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 16; c++)
        run("R13 branch", 13, 0, 0, pats[p], c);
  endtask

  task automatic t_sweep;  // R12
    for (int i = 0; i < 22; i++)
      run("R12 sweep", i, (i * 37 + 11) % 256, (i * 91 + 5) % 256, 6'((i * 13) % 64), i % 16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arith();
    t_logic();
    t_unary();
    t_shift();
    t_daa();
    t_mul();
    t_hold();
    t_branch();
    t_sweep();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule